// File: doc/BRIEF.md
# One-Hot Priority Grant Encoder

This block takes a request vector of `4*NUM_GRP` bits and returns a grant vector of the same width. At most one grant bit is set, and it is the grant bit for the highest-priority request that is active. Bit 0 has the highest priority overall. Priority falls as the bit index rises. The grant is one-hot. No binary index is produced, so a consumer can use each grant bit directly to enable the matching resource.

The vector is split into slices of four bits.

- Each slice detects whether it has any activity.
- Each slice picks its own first active bit through gated AND terms.
- A running OR runs from slice 0 upward through the slices. As soon as a slice with a lower index has a request, every slice with a higher index is switched off.

A parameter chooses the output timing. The outputs can be combinational, or they can pass through one register stage that has a synchronous active-low reset.

Top module: `onehot_prio_enc`

## Requirements
- R1: Every grant bit `grant_o[i]` is set only when the request bit `req_i[i]` with the same index is set.
- R2: At most one bit of `grant_o` is set at any time.
- R3: Priority falls as the index rises. The granted bit is the lowest-indexed set bit of `req_i`, so the grant equals `req_i & -req_i`.
- R4: Within one four-bit slice, bit 0 of the slice wins over bits 1 to 3, and bit 3 wins only when it is the slice's sole request.
- R5: A request in slice g is suppressed whenever any slice with a lower index (g-1 down to 0) holds a request.
- R6: `any_valid_o` is high exactly when `req_i` has at least one set bit. When all requests are zero, the grant is all zeros.
- R7: With `REG_OUT=1`, `grant_o` and `any_valid_o` show the result for the request that was present at the previous rising clock edge. While `rst_n` is low at a rising edge, the outputs clear to zero.
- R8: With `REG_OUT=0`, `grant_o` and `any_valid_o` follow `req_i` in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| req_i | input | 4*NUM_GRP | Request vector, bit 0 has the highest priority |
| grant_o | output | 4*NUM_GRP | One-hot grant, all zeros when there is no request |
| any_valid_o | output | 1 | High when at least one request is set |

## Verification
The properties sample `req_i` only at rising clock edges. They therefore assume that the requests are settled, known values at each edge, and they say nothing about glitches between edges. The bench changes `req_i` only on falling edges and never drives X or Z. Random vectors are thinned by ANDing several random words together, so they cover both sparse and dense patterns. Directed vectors place every four-bit pattern in every slice, which covers the masking between slices.

// File: rtl/prio_pkg.sv
// Package: shared constants for the one-hot priority grant encoder.
// Assumes: slices are always four bits wide; only the slice count varies.
package prio_pkg;
    localparam int unsigned SLICE_W = 4;
endpackage

// File: rtl/prio_slice.sv
// Module: prio_slice
// Purpose: resolve one four-bit slice. Bit 0 of the slice has the highest
// priority. The slice reports whether any of its bits is active, and it
// produces a one-hot pick gated by the enable it receives from the chain.
// Assumes: slice_en_i is low whenever a higher-priority slice is active.
module prio_slice
    import prio_pkg::*;
(
    input  logic [SLICE_W-1:0] req_i,
    input  logic               slice_en_i,
    output logic               active_o,
    output logic [SLICE_W-1:0] pick_o
);

    logic gate;

    // Activity detect: the OR of all four request bits in this slice
    always_comb active_o = |req_i;

    // Gate shared by every term: the slice is active and not killed
    always_comb gate = active_o & slice_en_i;

    generate
        for (genvar k = 0; k < SLICE_W; k++) begin : g_term
            if (k == 0) begin : g_top
                // Top-priority term: needs no inverted inputs
                always_comb pick_o[k] = req_i[k] & gate;
            end else begin : g_low
                // Lower term: blocked by any set bit below it in the slice
                always_comb pick_o[k] = req_i[k] & ~(|req_i[k-1:0]) & gate;
            end
        end
    endgenerate

endmodule

// File: rtl/prio_kill_chain.sv
// Module: prio_kill_chain
// Purpose: running OR from slice 0 upward. A slice is enabled only when no
// lower-indexed (higher-priority) slice is active. The final OR value
// doubles as the any-request flag.
// Assumes: slice_act_i[g] is the activity OR of slice g.
module prio_kill_chain #(
    parameter int unsigned NUM_GRP = 8
) (
    input  logic [NUM_GRP-1:0] slice_act_i,
    output logic [NUM_GRP-1:0] slice_en_o,
    output logic               any_o
);

    logic [NUM_GRP:0] seen;

    // Chain seed: nothing lies above slice 0
    always_comb seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_link
            // Accumulate activity of all slices with index up to g
            always_comb seen[g+1] = seen[g] | slice_act_i[g];
            // Enable slice g only when no earlier slice was active
            always_comb slice_en_o[g] = ~seen[g];
        end
    endgenerate

    // Any request anywhere in the vector
    always_comb any_o = seen[NUM_GRP];

endmodule

// File: rtl/prio_out_stage.sv
// Module: prio_out_stage
// Purpose: optional output register. With REG_OUT=1 the grant and valid
// flag are registered, with a synchronous active-low reset to zero. With
// REG_OUT=0 they pass straight through.
// Assumes: the inputs come from combinational logic clocked by clk.
module prio_out_stage #(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] grant_d,
    input  logic             valid_d,
    output logic [WIDTH-1:0] grant_q,
    output logic             valid_q
);

    generate
        if (REG_OUT) begin : g_reg
            // Register the grant and valid flag; reset clears both
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    grant_q <= '0;
                    valid_q <= 1'b0;
                end else begin
                    grant_q <= grant_d;
                    valid_q <= valid_d;
                end
            end

            AST_REG_LAG: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (grant_q == $past(grant_d) && valid_q == $past(valid_d))); // R7
            AST_RESET_CLEAR: assert property (@(posedge clk)
                !rst_n |=> (grant_q == '0 && !valid_q)); // R7
        end else begin : g_wire
            // Pass-through: the outputs follow the inputs in the same cycle
            always_comb grant_q = grant_d;
            always_comb valid_q = valid_d;
        end
    endgenerate

endmodule

// File: rtl/onehot_prio_enc.sv
// Module: onehot_prio_enc
// Purpose: one-hot priority grant over 4*NUM_GRP requests. Bit 0 has the
// highest priority. Slices resolve locally, and a kill chain masks the
// slices behind an active one. An optional register stage follows.
// Assumes: req_i is a stable, known value at each rising clock edge.
module onehot_prio_enc
    import prio_pkg::*;
#(
    parameter int unsigned NUM_GRP = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLICE_W*NUM_GRP-1:0] req_i,
    output logic [SLICE_W*NUM_GRP-1:0] grant_o,
    output logic                       any_valid_o
);

    localparam int unsigned WIDTH = SLICE_W * NUM_GRP;

    logic [NUM_GRP-1:0] slice_act;
    logic [NUM_GRP-1:0] slice_en;
    logic [WIDTH-1:0]   grant_c;
    logic               any_c;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_slice
            prio_slice u_slice (
                .req_i      (req_i[g*SLICE_W +: SLICE_W]),
                .slice_en_i (slice_en[g]),
                .active_o   (slice_act[g]),
                .pick_o     (grant_c[g*SLICE_W +: SLICE_W])
            );
        end
    endgenerate

    prio_kill_chain #(.NUM_GRP(NUM_GRP)) u_chain (
        .slice_act_i (slice_act),
        .slice_en_o  (slice_en),
        .any_o       (any_c)
    );

    prio_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_d (grant_c),
        .valid_d (any_c),
        .grant_q (grant_o),
        .valid_q (any_valid_o)
    );

    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_c & ~req_i) == '0); // R1
    AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_c)); // R2
    AST_NO_EARLIER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_c != '0) |-> (((grant_c - 1'b1) & req_i) == '0)); // R3
    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        any_c == (grant_c != '0)); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |-> (grant_c == '0 && !any_c)); // R6

endmodule

// File: tb/onehot_prio_enc_test.sv
module onehot_prio_enc_test;

    localparam int unsigned NG = 8;
    localparam int unsigned W  = 4 * NG;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] req = '0;
    logic [W-1:0] grant_r, grant_c;
    logic         valid_r, valid_c;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    onehot_prio_enc #(.NUM_GRP(NG), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .grant_o(grant_r), .any_valid_o(valid_r)
    );

    onehot_prio_enc #(.NUM_GRP(NG), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .grant_o(grant_c), .any_valid_o(valid_c)
    );

    function automatic logic [W-1:0] exp_grant(input logic [W-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive v on a falling edge, check the comb copy, then the registered copy
    task automatic apply(input logic [W-1:0] v, input string tag);
        @(negedge clk);
        req = v;
        #1;
        chk({tag, " R8 comb grant"}, grant_c, exp_grant(v));
        chk({tag, " R6 comb valid"}, {31'd0, valid_c}, {31'd0, v != '0});
        @(negedge clk);
        chk({tag, " R3 reg grant"}, grant_r, exp_grant(v));
        chk({tag, " R7 reg valid"}, {31'd0, valid_r}, {31'd0, v != '0});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired R7 actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240825));
        // R7: reset state
        repeat (3) @(negedge clk);
        chk("R7 reset grant", grant_r, '0);
        chk("R7 reset valid", {31'd0, valid_r}, '0);
        rst_n = 1'b1;

        // R6: all-zero request
        apply('0, "R6 idle");
        // R1/R2: single bits at every position
        for (int i = 0; i < W; i++) apply(W'(1) << i, "R1 single");
        // R3: all ones -> bit 0
        apply('1, "R3 all ones");
        // R4: every in-slice pattern in every slice
        for (int g = 0; g < NG; g++)
            for (int p = 1; p < 16; p++)
                apply(W'(p) << (4 * g), "R4 slice");
        // R5: lower slice masks every higher slice
        for (int g = 0; g < NG - 1; g++)
            apply((W'(4'b1000) << (4 * g)) | (W'(4'b0001) << (4 * (g + 1))), "R5 mask");
        apply(32'h8000_0000, "R5 last only");
        // R2/R3: random vectors, sparse and dense
        for (int n = 0; n < 1500; n++) begin
            logic [W-1:0] v;
            case (n % 4)
                0: v = $urandom;
                1: v = $urandom & $urandom;
                2: v = $urandom & $urandom & $urandom & $urandom;
                default: v = ($urandom & $urandom & $urandom) & ~((W'(1) << ($urandom % W)) - 1'b1);
            endcase
            apply(v, "R2 random");
        end

        // R7: reset asserted mid-run clears the registered outputs
        @(negedge clk);
        req = 32'h0000_0100;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 mid reset grant", grant_r, '0);
        chk("R7 mid reset valid", {31'd0, valid_r}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 after reset grant", grant_r, 32'h0000_0100);
        finish_run();
    end

endmodule